// File: doc/BRIEF.md
# Serial transfer multi-buffer RAM

This block is the buffer store that sits between a host bus and the shift engine of a serial peripheral controller. It has two banks of equal depth: an outgoing bank and an incoming bank. Each outgoing word pairs 16 bits of data to send with 16 bits of per-transfer control. Each incoming word pairs 16 bits of received data with 16 bits of status. A parameter picks 128 words per bank, or 256 in the extended build.

The host sees both banks through one byte-addressed map. The outgoing bank comes first and is readable and writable, with a byte enable for each lane. The incoming bank sits directly above it and is read-only from the host. The engine has its own port. On that port it fetches outgoing words, and it deposits each finished transfer into the incoming word of the same index. While it does so, the block copies the chip-select byte of the matching outgoing control half into the incoming status half.

Every stored word carries four parity bits that the block generates on write. The block checks them on every read from either port. A mismatch raises a one-cycle error pulse and records which word failed. A test input inverts the generated parity, so that the check path can be exercised in place.

Top module: `spi_buf_ram`

## Requirements
- R1: A host access with `host_we_i`=1 and address bit 9 (the top bit of `host_addr_i`) clear writes outgoing word `host_addr_i[8:2]`. Lane l is bits 8l+7..8l and is written only where `host_be_i[l]`=1. A host read returns the addressed word on `host_rdata_o` one cycle after the request, and that value holds until the next host read.
- R2: A partial host write leaves the unselected byte lanes of the word, and their parity, unchanged.
- R3: Host writes with address bit 9 set (the incoming window, byte 0x200 to 0x3FC) change nothing. Engine writes to the incoming bank always land.
- R4: An engine write (`eng_wr_i`) to index N stores `{eng_stat_i, outgoing word N bits 23:16, eng_rx_data_i}` in incoming word N. The middle byte is the chip-select number read from the outgoing control half in that same cycle.
- R5: An engine read (`eng_rd_i`) returns outgoing word `eng_rd_idx_i` on `eng_rdata_o` one cycle later, and that value holds until the next engine read.
- R6: Parity bit l of a word is the even parity of lane l, stored when that lane is written. Reading a word whose lanes were all written with `par_inv_i`=0 gives no error.
- R7: A lane written while `par_inv_i`=1 stores inverted parity. A later read of that word on either port raises `par_err_o` for exactly the one cycle in which the read data appears.
- R8: `err_addr_o` = {bank, index}, with bank 0 for outgoing and 1 for incoming. It is loaded one cycle after an error pulse and holds otherwise. If both ports fail in the same cycle, the engine read's address is recorded.
- R9: After reset, `host_rdata_o`, `eng_rdata_o`, `par_err_o` and `err_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | IDX_W+1 | Byte address bits [IDX_W+2:2]; the top bit selects the incoming bank |
| host_be_i | input | 4 | Byte-lane write enables |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, one cycle latency |
| eng_rd_i | input | 1 | Engine read of the outgoing bank |
| eng_rd_idx_i | input | IDX_W | Engine read index |
| eng_rdata_o | output | 32 | Engine read data, one cycle latency |
| eng_wr_i | input | 1 | Engine write of a finished transfer |
| eng_wr_idx_i | input | IDX_W | Engine write index |
| eng_rx_data_i | input | 16 | Received data |
| eng_stat_i | input | 8 | Upper status byte |
| par_inv_i | input | 1 | Invert generated parity (test) |
| par_err_o | output | 1 | Parity error pulse |
| err_addr_o | output | IDX_W+1 | Bank and index of the last failing read |

## Verification
The hardest case to reach is a pair of parity failures on both ports in the same cycle. The host cannot corrupt the incoming bank, so the bench first has the engine write one incoming word with the parity-invert input held high. It then corrupts one lane of an outgoing word through a partial host write. Finally it issues a host read of the bad incoming word and an engine read of the bad outgoing word on the same edge, with the error address register preloaded with the incoming word's address so that a wrong priority shows up as a different value.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int LANES = 4;

  function automatic logic [LANES-1:0] lane_par(input logic [31:0] w);
    logic [LANES-1:0] p;
    for (int l = 0; l < LANES; l++) p[l] = ^w[8*l +: 8];
    return p;
  endfunction
endpackage

// File: rtl/buf_rd_port.sv
module buf_rd_port
  import spi_buf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [31:0]      word_i,
  input  logic [LANES-1:0] par_i,
  output logic [31:0]      data_o,
  output logic             perr_o
);
  logic [LANES-1:0] par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      par_q  <= '0;
    end else if (en_i) begin
      data_o <= word_i;
      par_q  <= par_i;
    end
  end

  assign perr_o = |(lane_par(data_o) ^ par_q);

  // R1 / R5: read data holds between reads
  a_r5_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o));
endmodule

// File: rtl/buf_tx_bank.sv
module buf_tx_bank
  import spi_buf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LANES-1:0] wr_be_i,
  input  logic [31:0]      wr_data_i,
  input  logic             par_inv_i,
  input  logic             ha_en_i,
  input  logic [IDX_W-1:0] ha_idx_i,
  output logic [31:0]      ha_data_o,
  output logic             ha_perr_o,
  input  logic             eb_en_i,
  input  logic [IDX_W-1:0] eb_idx_i,
  output logic [31:0]      eb_data_o,
  output logic             eb_perr_o,
  input  logic [IDX_W-1:0] csn_idx_i,
  output logic [7:0]       csn_o
);
  logic [31:0]      mem_q [DEPTH];
  logic [LANES-1:0] par_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be_i[l]) begin
          mem_q[wr_idx_i][8*l +: 8] <= wr_data_i[8*l +: 8];
          par_q[wr_idx_i][l]        <= (^wr_data_i[8*l +: 8]) ^ par_inv_i;
        end
      end
    end
  end

  // chip-select byte of the control half, read before this cycle's write
  assign csn_o = mem_q[csn_idx_i][23:16];

  buf_rd_port i_port_host (
    .clk_i, .rst_ni,
    .en_i   (ha_en_i),
    .word_i (mem_q[ha_idx_i]),
    .par_i  (par_q[ha_idx_i]),
    .data_o (ha_data_o),
    .perr_o (ha_perr_o)
  );

  buf_rd_port i_port_eng (
    .clk_i, .rst_ni,
    .en_i   (eb_en_i),
    .word_i (mem_q[eb_idx_i]),
    .par_i  (par_q[eb_idx_i]),
    .data_o (eb_data_o),
    .perr_o (eb_perr_o)
  );
endmodule

// File: rtl/buf_rx_bank.sv
module buf_rx_bank
  import spi_buf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic             par_inv_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o,
  output logic             rd_perr_o
);
  logic [31:0]      mem_q [DEPTH];
  logic [LANES-1:0] par_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
      par_q[wr_idx_i] <= lane_par(wr_data_i) ^ {LANES{par_inv_i}};
    end
  end

  buf_rd_port i_port (
    .clk_i, .rst_ni,
    .en_i   (rd_en_i),
    .word_i (mem_q[rd_idx_i]),
    .par_i  (par_q[rd_idx_i]),
    .data_o (rd_data_o),
    .perr_o (rd_perr_o)
  );
endmodule

// File: rtl/spi_buf_ram.sv
module spi_buf_ram
  import spi_buf_pkg::*;
#(
  parameter bit EXT_BUF = 1'b0,
  localparam int DEPTH = EXT_BUF ? 256 : 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_req_i,
  input  logic             host_we_i,
  input  logic [AW-1:2]    host_addr_i,
  input  logic [LANES-1:0] host_be_i,
  input  logic [31:0]      host_wdata_i,
  output logic [31:0]      host_rdata_o,
  input  logic             eng_rd_i,
  input  logic [IDX_W-1:0] eng_rd_idx_i,
  output logic [31:0]      eng_rdata_o,
  input  logic             eng_wr_i,
  input  logic [IDX_W-1:0] eng_wr_idx_i,
  input  logic [15:0]      eng_rx_data_i,
  input  logic [7:0]       eng_stat_i,
  input  logic             par_inv_i,
  output logic             par_err_o,
  output logic [IDX_W:0]   err_addr_o
);
  logic             h_bank, h_rd, tx_we;
  logic [IDX_W-1:0] h_idx;
  logic [7:0]       csn;
  logic [31:0]      tx_hd, rx_hd;
  logic             tx_hperr, rx_hperr, tx_eperr;
  logic             h_vld_q, h_bank_q, e_vld_q;
  logic [IDX_W-1:0] h_idx_q, e_idx_q;
  logic             h_err, e_err;

  assign h_bank = host_addr_i[AW-1];
  assign h_idx  = host_addr_i[AW-2:2];
  assign h_rd   = host_req_i && !host_we_i;
  // incoming window is read-only: host writes there are dropped
  assign tx_we  = host_req_i && host_we_i && !h_bank;

  buf_tx_bank #(.DEPTH(DEPTH)) i_tx (
    .clk_i, .rst_ni,
    .wr_en_i   (tx_we),
    .wr_idx_i  (h_idx),
    .wr_be_i   (host_be_i),
    .wr_data_i (host_wdata_i),
    .par_inv_i (par_inv_i),
    .ha_en_i   (h_rd && !h_bank),
    .ha_idx_i  (h_idx),
    .ha_data_o (tx_hd),
    .ha_perr_o (tx_hperr),
    .eb_en_i   (eng_rd_i),
    .eb_idx_i  (eng_rd_idx_i),
    .eb_data_o (eng_rdata_o),
    .eb_perr_o (tx_eperr),
    .csn_idx_i (eng_wr_idx_i),
    .csn_o     (csn)
  );

  buf_rx_bank #(.DEPTH(DEPTH)) i_rx (
    .clk_i, .rst_ni,
    .wr_en_i   (eng_wr_i),
    .wr_idx_i  (eng_wr_idx_i),
    .wr_data_i ({eng_stat_i, csn, eng_rx_data_i}),
    .par_inv_i (par_inv_i),
    .rd_en_i   (h_rd && h_bank),
    .rd_idx_i  (h_idx),
    .rd_data_o (rx_hd),
    .rd_perr_o (rx_hperr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_vld_q  <= 1'b0;
      h_bank_q <= 1'b0;
      h_idx_q  <= '0;
      e_vld_q  <= 1'b0;
      e_idx_q  <= '0;
    end else begin
      h_vld_q <= h_rd;
      e_vld_q <= eng_rd_i;
      if (h_rd) begin
        h_bank_q <= h_bank;
        h_idx_q  <= h_idx;
      end
      if (eng_rd_i) e_idx_q <= eng_rd_idx_i;
    end
  end

  assign host_rdata_o = h_bank_q ? rx_hd : tx_hd;
  assign h_err        = h_vld_q && (h_bank_q ? rx_hperr : tx_hperr);
  assign e_err        = e_vld_q && tx_eperr;
  assign par_err_o    = h_err || e_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_addr_o <= '0;
    else if (e_err) err_addr_o <= {1'b0, e_idx_q};
    else if (h_err) err_addr_o <= {h_bank_q, h_idx_q};
  end

  a_r1_host_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_rd |=> $stable(host_rdata_o));

  a_r7_err_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> $past(h_rd || eng_rd_i));

  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_err_o |=> $stable(err_addr_o));
endmodule

// File: tb/test_spi_buf_ram.sv
module test_spi_buf_ram;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        host_req_i = 0, host_we_i = 0;
  logic [9:2]  host_addr_i = '0;
  logic [3:0]  host_be_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic        eng_rd_i = 0;
  logic [6:0]  eng_rd_idx_i = '0;
  logic [31:0] eng_rdata_o;
  logic        eng_wr_i = 0;
  logic [6:0]  eng_wr_idx_i = '0;
  logic [15:0] eng_rx_data_i = '0;
  logic [7:0]  eng_stat_i = '0;
  logic        par_inv_i = 0;
  logic        par_err_o;
  logic [7:0]  err_addr_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] txm [N];
  logic [31:0] rxm [N];
  logic [3:0]  txb [N];
  logic [3:0]  rxb [N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_buf_ram i_spi_buf_ram (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d, input logic inv);
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 1; host_addr_i = a; host_be_i = be; host_wdata_i = d; par_inv_i = inv;
    @(negedge clk_i);
    host_req_i = 0; host_we_i = 0; par_inv_i = 0;
    if (!a[7]) for (int l = 0; l < 4; l++)
      if (be[l]) begin
        txm[a[6:0]][8*l +: 8] = d[8*l +: 8];
        txb[a[6:0]][l] = inv;
      end
  endtask

  task automatic host_rd(input string req, input logic [7:0] a);
    logic [31:0] e;
    logic        be;
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 0; host_addr_i = a;
    @(negedge clk_i);
    host_req_i = 0;
    e  = a[7] ? rxm[a[6:0]] : txm[a[6:0]];
    be = a[7] ? |rxb[a[6:0]] : |txb[a[6:0]];
    chk(req, host_rdata_o, e);
    chk({req, " err"}, {31'd0, par_err_o}, {31'd0, be});
  endtask

  task automatic eng_rd(input string req, input logic [6:0] i);
    @(negedge clk_i);
    eng_rd_i = 1; eng_rd_idx_i = i;
    @(negedge clk_i);
    eng_rd_i = 0;
    chk(req, eng_rdata_o, txm[i]);
    chk({req, " err"}, {31'd0, par_err_o}, {31'd0, |txb[i]});
  endtask

  task automatic eng_wr(input logic [6:0] i, input logic [15:0] d, input logic [7:0] s, input logic inv);
    @(negedge clk_i);
    eng_wr_i = 1; eng_wr_idx_i = i; eng_rx_data_i = d; eng_stat_i = s; par_inv_i = inv;
    @(negedge clk_i);
    eng_wr_i = 0; par_inv_i = 0;
    rxm[i] = {s, txm[i][23:16], d};
    rxb[i] = {4{inv}};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9 host_rdata", host_rdata_o, 0);
    chk("R9 eng_rdata", eng_rdata_o, 0);
    chk("R9 par_err", {31'd0, par_err_o}, 0);
    chk("R9 err_addr", {24'd0, err_addr_o}, 0);
    rst_ni = 1;

    // R1 / R6: full-word fill and readback of the outgoing bank
    for (int i = 0; i < N; i++) host_wr({1'b0, 7'(i)}, 4'hF, (i * 32'h0103_0507) ^ 32'h5AC3_3C96, 0);
    for (int i = 0; i < N; i++) host_rd("R1 R6 host tx read", {1'b0, 7'(i)});
    // R5: engine port sweep
    for (int i = 0; i < N; i++) eng_rd("R5 engine read", 7'(i));

    // R2: every byte-enable pattern
    for (int b = 0; b < 16; b++) begin
      host_wr({1'b0, 7'(20 + b)}, 4'(b), ~(b * 32'h1111_1111), 0);
      host_rd("R2 partial write", {1'b0, 7'(20 + b)});
    end

    // R4: engine deposits, chip-select byte mirrored
    for (int i = 0; i < N; i++) eng_wr(7'(i), 16'(i * 3 + 7), ~8'(i), 0);
    for (int i = 0; i < N; i++) host_rd("R4 rx word", {1'b1, 7'(i)});

    // R3: host writes to the incoming window are dropped
    for (int i = 0; i < 8; i++) begin
      host_wr({1'b1, 7'(i)}, 4'hF, 32'hDEAD_BEEF, 0);
      host_rd("R3 rx read-only", {1'b1, 7'(i)});
    end
    // R3: same-cycle host and engine write to one incoming word
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 1; host_addr_i = {1'b1, 7'd9}; host_be_i = 4'hF; host_wdata_i = 32'h0BAD_0BAD;
    eng_wr_i = 1; eng_wr_idx_i = 7'd9; eng_rx_data_i = 16'hC0DE; eng_stat_i = 8'h42;
    @(negedge clk_i);
    host_req_i = 0; host_we_i = 0; eng_wr_i = 0;
    rxm[9] = {8'h42, txm[9][23:16], 16'hC0DE};
    host_rd("R3 engine wins", {1'b1, 7'd9});

    // R7 / R8: corrupt one lane of outgoing word 40
    host_wr({1'b0, 7'd40}, 4'b0100, 32'h00AB_0000, 1);
    host_rd("R7 host detect", {1'b0, 7'd40});
    @(negedge clk_i);
    chk("R7 one-cycle pulse", {31'd0, par_err_o}, 0);
    chk("R8 err_addr host", {24'd0, err_addr_o}, {24'd0, 8'd40});
    eng_rd("R7 engine detect", 7'd40);
    @(negedge clk_i);
    chk("R8 err_addr engine", {24'd0, err_addr_o}, {24'd0, 8'd40});
    eng_rd("R6 clean word", 7'd41);
    @(negedge clk_i);
    chk("R8 err_addr holds", {24'd0, err_addr_o}, {24'd0, 8'd40});

    // corrupt incoming word 60 through the engine
    eng_wr(7'd60, 16'h1234, 8'h99, 1);
    host_rd("R7 rx detect", {1'b1, 7'd60});
    @(negedge clk_i);
    chk("R8 err_addr rx", {24'd0, err_addr_o}, {24'd0, 8'h80 | 8'd60});

    // R8: simultaneous failures, engine address recorded
    @(negedge clk_i);
    host_req_i = 1; host_we_i = 0; host_addr_i = {1'b1, 7'd60};
    eng_rd_i = 1; eng_rd_idx_i = 7'd40;
    @(negedge clk_i);
    host_req_i = 0; eng_rd_i = 0;
    chk("R7 dual pulse", {31'd0, par_err_o}, 1);
    @(negedge clk_i);
    chk("R8 engine priority", {24'd0, err_addr_o}, {24'd0, 8'd40});

    // R6: rewriting all lanes clears the fault
    host_wr({1'b0, 7'd40}, 4'hF, 32'h7777_0001, 0);
    host_rd("R6 repaired", {1'b0, 7'd40});
    eng_rd("R6 repaired engine", 7'd40);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule